// File: doc/BRIEF.md
# Clock Source Selector with Fault Fallback

This block picks the system clock from two free-running sources: an internal RC oscillator and an external crystal oscillator. Out of reset the internal source always drives the output. Software moves the output to the external source by holding a request level high. It moves back by dropping that level. The hand-over is glitch-free. The enable of the source being left drops on that source's own falling edge. Only after it has dropped is the enable of the new source raised, on the new source's own falling edge.

The block watches the external clock from the internal domain with a round-trip toggle handshake. If no handshake completes within `MISS_LIMIT` internal cycles, the external clock is treated as missing. In that case the block sets a sticky fault flag and forces the output back to the internal source without any software action. While the flag is set, a request for the external source is ignored. The flag clears only on a clear strobe given while the external clock is alive. The flag is set at reset, so software must clear it once before the first switch.

The control state machine has four states:
- `ST_RUN_RC`: internal source driving. It goes to `ST_TO_XT` on a request with the flag clear.
- `ST_TO_XT`: hand-over in progress. It goes to `ST_RUN_XT` once the external gate is seen on and the internal gate is off. It goes to `ST_TO_RC` on a fault or when the request drops.
- `ST_RUN_XT`: external source driving. It goes to `ST_TO_RC` on a fault or when the request drops.
- `ST_TO_RC`: returning. It goes to `ST_RUN_RC` once the internal gate is on and the external gate is seen off.

Top module: `clk_source_selector`

## Requirements
- R1: After reset, `clk_out` follows `clk_rc`, `src_xt` is 0, `osc_fault` is 1 and `switch_done` is 1.
- R2: While `sel_xt_req` is 1 and `osc_fault` is 0, the block settles with `src_xt` = 1, `switch_done` = 1, and `clk_out` toggling at the external clock's rate.
- R3: While `osc_fault` is 1, a high `sel_xt_req` is ignored: `src_xt` stays 0 and `clk_out` keeps following `clk_rc`.
- R4: When no activity handshake with the external clock completes for `MISS_LIMIT` (default 8) consecutive internal cycles, `osc_fault` is set within a few cycles after that.
- R5: On a detected external clock loss, the output reverts to `clk_rc` and `src_xt` returns to 0 with no software action.
- R6: `osc_fault` is sticky. A one-cycle `fault_clr` pulse clears it only while the external clock is alive. A pulse given while the external clock is stopped has no effect.
- R7: `clk_out` shows no pulse, high or low, narrower than the narrower half-period of the two sources. The two source gates are never on together.
- R8: `src_xt` reports the source actually gated onto `clk_out`. `switch_done` is 0 while a hand-over is in progress and 1 once it has settled.
- R9: Dropping `sel_xt_req` to 0 returns the output to `clk_rc` and sets `src_xt` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC oscillator clock; runs the control logic |
| clk_xt | input | 1 | External crystal oscillator clock; may stop at any time |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| sel_xt_req | input | 1 | Level request: 1 selects the external source, 0 the internal one |
| fault_clr | input | 1 | One-cycle strobe that clears the sticky fault flag |
| clk_out | output | 1 | Selected, glitch-free system clock |
| src_xt | output | 1 | 1 when the external source is driving `clk_out` |
| osc_fault | output | 1 | Sticky external-oscillator fault flag |
| switch_done | output | 1 | 1 when no source hand-over is in progress |

## Verification
The assertions check on every internal-clock cycle that the two gates are never on together. They also check that a missing external clock sets the flag, that the flag holds without a valid clear, and that a set flag keeps the machine in `ST_RUN_RC` or forces it out of `ST_RUN_XT`. A last assertion checks that `ST_RUN_XT` is only held while the external gate is on. The output's pulse widths and edge rate, the clear strobe's dependence on a live external clock, and the return to the internal source after the external clock stops can only be shown by the bench's scenarios. These cross both clock domains and are observed as waveforms at the ports.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

    typedef enum logic [1:0] {
        ST_RUN_RC = 2'd0,
        ST_TO_XT  = 2'd1,
        ST_RUN_XT = 2'd2,
        ST_TO_RC  = 2'd3
    } sel_state_t;

endpackage

// File: rtl/clk_gate_branch.sv
`timescale 1ns/1ps
// One leg of the glitch-free mux: the enable request is synchronised on the
// rising edge of the leg's own clock, then the gate is updated on the falling
// edge, so the gate only changes while the clock is low.
module clk_gate_branch #(
    parameter int SYNC_STAGES = 2,
    parameter bit RST_ON      = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en_req,
    output logic gate_on,
    output logic clk_gated
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   gate_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sync_q <= {SYNC_STAGES{RST_ON}};
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], en_req};
        end
    end

    always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) begin
            gate_q <= RST_ON;
        end else begin
            gate_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign gate_on   = gate_q;
    assign clk_gated = clk & gate_q;
endmodule

// File: rtl/xt_activity_monitor.sv
`timescale 1ns/1ps
// Round-trip toggle handshake: the internal domain flips a request, the
// external domain echoes it back through synchronisers. Each completed echo
// proves the external clock is alive. A timeout counter declares it missing.
module xt_activity_monitor #(
    parameter int MISS_LIMIT  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_rc,
    input  logic clk_xt,
    input  logic rst_n,
    output logic xt_alive
);
    localparam int CW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MISS_LIMIT);

    logic                   ping_q;
    logic [SYNC_STAGES-1:0] echo_xt_q;
    logic [SYNC_STAGES-1:0] echo_rc_q;
    logic [CW-1:0]          idle_cnt_q;
    logic                   round_done;

    // external domain: carry the ping across
    always_ff @(posedge clk_xt or negedge rst_n) begin
        if (!rst_n) begin
            echo_xt_q <= '0;
        end else begin
            echo_xt_q <= {echo_xt_q[SYNC_STAGES-2:0], ping_q};
        end
    end

    // internal domain: bring the echo back
    always_ff @(posedge clk_rc or negedge rst_n) begin
        if (!rst_n) begin
            echo_rc_q <= '0;
        end else begin
            echo_rc_q <= {echo_rc_q[SYNC_STAGES-2:0], echo_xt_q[SYNC_STAGES-1]};
        end
    end

    assign round_done = (echo_rc_q[SYNC_STAGES-1] == ping_q);

    // ping starts opposite to the echo so nothing counts as done at reset
    always_ff @(posedge clk_rc or negedge rst_n) begin
        if (!rst_n) begin
            ping_q     <= 1'b1;
            idle_cnt_q <= LIMIT;
        end else if (round_done) begin
            ping_q     <= ~ping_q;
            idle_cnt_q <= '0;
        end else if (idle_cnt_q != LIMIT) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    assign xt_alive = (idle_cnt_q < LIMIT);
endmodule

// File: rtl/clk_source_selector.sv
`timescale 1ns/1ps
module clk_source_selector
    import clksel_pkg::*;
#(
    parameter int MISS_LIMIT  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_rc,
    input  logic clk_xt,
    input  logic rst_n,
    input  logic sel_xt_req,
    input  logic fault_clr,
    output logic clk_out,
    output logic src_xt,
    output logic osc_fault,
    output logic switch_done
);
    sel_state_t             state_q, state_d;
    logic                   fault_q;
    logic                   xt_alive;
    logic                   want_xt;
    logic                   rc_gate_on, xt_gate_on;
    logic                   rc_clk_g, xt_clk_g;
    logic                   xt_arst_n;
    logic [SYNC_STAGES-1:0] xt_on_sync_q;
    logic                   xt_on_s;

    xt_activity_monitor #(
        .MISS_LIMIT (MISS_LIMIT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
        .clk_rc  (clk_rc),
        .clk_xt  (clk_xt),
        .rst_n   (rst_n),
        .xt_alive(xt_alive)
    );

    // sticky fault: set while the external clock is missing (and at reset)
    always_ff @(posedge clk_rc or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b1;
        end else if (!xt_alive) begin
            fault_q <= 1'b1;
        end else if (fault_clr) begin
            fault_q <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk_rc or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN_RC;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN_RC: if (sel_xt_req && !fault_q) state_d = ST_TO_XT;
            ST_TO_XT: begin
                if (fault_q || !sel_xt_req)      state_d = ST_TO_RC;
                else if (xt_on_s && !rc_gate_on) state_d = ST_RUN_XT;
            end
            ST_RUN_XT: if (fault_q || !sel_xt_req) state_d = ST_TO_RC;
            ST_TO_RC:  if (rc_gate_on && !xt_on_s) state_d = ST_RUN_RC;
            default:   state_d = ST_RUN_RC;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        want_xt     = 1'b0;
        switch_done = 1'b0;
        unique case (state_q)
            ST_RUN_RC: switch_done = 1'b1;
            ST_TO_XT:  want_xt     = 1'b1;
            ST_RUN_XT: begin
                want_xt     = 1'b1;
                switch_done = 1'b1;
            end
            ST_TO_RC:  want_xt     = 1'b0;
            default:   want_xt     = 1'b0;
        endcase
    end

    // a fault drops the external leg at once, even with its clock stopped
    assign xt_arst_n = rst_n & ~fault_q;

    clk_gate_branch #(
        .SYNC_STAGES(SYNC_STAGES),
        .RST_ON     (1'b1)
    ) u_rc_leg (
        .clk      (clk_rc),
        .arst_n   (rst_n),
        .en_req   (~want_xt & ~xt_gate_on),
        .gate_on  (rc_gate_on),
        .clk_gated(rc_clk_g)
    );

    clk_gate_branch #(
        .SYNC_STAGES(SYNC_STAGES),
        .RST_ON     (1'b0)
    ) u_xt_leg (
        .clk      (clk_xt),
        .arst_n   (xt_arst_n),
        .en_req   (want_xt & ~rc_gate_on),
        .gate_on  (xt_gate_on),
        .clk_gated(xt_clk_g)
    );

    // external gate state seen from the internal domain
    always_ff @(posedge clk_rc or negedge rst_n) begin
        if (!rst_n) begin
            xt_on_sync_q <= '0;
        end else begin
            xt_on_sync_q <= {xt_on_sync_q[SYNC_STAGES-2:0], xt_gate_on};
        end
    end
    assign xt_on_s = xt_on_sync_q[SYNC_STAGES-1];

    assign clk_out   = rc_clk_g | xt_clk_g;
    assign src_xt    = xt_on_s;
    assign osc_fault = fault_q;
endmodule

// File: rtl/clksel_checker.sv
`timescale 1ns/1ps
module clksel_checker
    import clksel_pkg::*;
(
    input logic       clk_rc,
    input logic       rst_n,
    input sel_state_t st,
    input logic       fault_q,
    input logic       xt_alive,
    input logic       fault_clr,
    input logic       rc_gate,
    input logic       xt_gate,
    input logic       xt_on_s
);
    // R7: both legs never gated on together
    a_r7_one_gate: assert property (@(posedge clk_rc) disable iff (!rst_n)
        !(rc_gate && xt_gate));

    // R4: a missing external clock sets the flag
    a_r4_miss_sets_fault: assert property (@(posedge clk_rc) disable iff (!rst_n)
        !xt_alive |=> fault_q);

    // R6: the flag holds without a clear strobe
    a_r6_fault_sticky: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (fault_q && !fault_clr) |=> fault_q);

    // R6: a clear strobe is ineffective while the external clock is missing
    a_r6_clear_needs_alive: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (fault_q && !xt_alive) |=> fault_q);

    // R3: with the flag set, the machine never leaves the internal run state
    a_r3_no_switch_under_fault: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (st == ST_RUN_RC && fault_q) |=> (st == ST_RUN_RC));

    // R5: a fault forces the return from the external run state
    a_r5_fault_exits_xt: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (st == ST_RUN_XT && fault_q) |=> (st == ST_TO_RC));

    // R8: the external run state is only held while the external gate is on
    a_r8_xt_status: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (st == ST_RUN_XT) |-> xt_on_s);
endmodule

bind clk_source_selector clksel_checker u_chk (
    .clk_rc   (clk_rc),
    .rst_n    (rst_n),
    .st       (state_q),
    .fault_q  (fault_q),
    .xt_alive (xt_alive),
    .fault_clr(fault_clr),
    .rc_gate  (rc_gate_on),
    .xt_gate  (xt_gate_on),
    .xt_on_s  (xt_on_s)
);

// File: tb/sim_clk_source_selector.sv
`timescale 1ns/1ps
module sim_clk_source_selector;
    logic clk_rc = 1'b0;
    logic clk_xt = 1'b0;
    logic rst_n = 1'b0;
    logic sel_xt_req = 1'b0;
    logic fault_clr = 1'b0;
    logic xt_run = 1'b0;
    logic clk_out, src_xt, osc_fault, switch_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model
    bit m_fault = 1'b1;
    bit m_running = 1'b0;
    bit m_req = 1'b0;

    // output monitors
    int    edge_cnt = 0;
    int    runts = 0;
    bit    arm = 1'b0;
    realtime t_rise = 0.0;
    realtime t_fall = 0.0;

    always #2 clk_rc = ~clk_rc;                          // 250 MHz internal
    always #1.5 clk_xt = xt_run ? ~clk_xt : 1'b0;        // external, stops low

    clk_source_selector u0 (
        .clk_rc     (clk_rc),
        .clk_xt     (clk_xt),
        .rst_n      (rst_n),
        .sel_xt_req (sel_xt_req),
        .fault_clr  (fault_clr),
        .clk_out    (clk_out),
        .src_xt     (src_xt),
        .osc_fault  (osc_fault),
        .switch_done(switch_done)
    );

    always @(posedge clk_out) begin
        edge_cnt++;
        if (arm && ($realtime - t_fall) < 1.4) runts++;
        t_rise = $realtime;
    end
    always @(negedge clk_out) begin
        if (arm && ($realtime - t_rise) < 1.4) runts++;
        t_fall = $realtime;
    end

    function automatic int exp_src(bit req, bit fault);
        return (req && !fault) ? 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_rc(input int n);
        repeat (n) @(negedge clk_rc);
    endtask

    // count clk_out rising edges over 100 internal cycles
    task automatic measure_rate(output int n);
        int c0;
        @(negedge clk_rc);
        c0 = edge_cnt;
        wait_rc(100);
        n = edge_cnt - c0;
    endtask

    task automatic strobe_clear();
        @(negedge clk_rc) fault_clr = 1'b1;
        @(negedge clk_rc) fault_clr = 1'b0;
        if (m_running) m_fault = 1'b0;
    endtask

    task automatic check_model(input string tag);
        check({tag, " src_xt"}, int'(src_xt), exp_src(m_req, m_fault));
        check({tag, " osc_fault"}, int'(osc_fault), int'(m_fault));
        check({tag, " switch_done"}, int'(switch_done), 1);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int rate;
        int lat;
        bit saw_busy;
        int unused_seed;
        unused_seed = $urandom(32'h00C1_0C5E);

        wait_rc(5);
        rst_n = 1'b1;
        wait_rc(20);
        arm = 1'b1;

        // R1: reset state, external absent
        check("R1 src_xt", int'(src_xt), 0);
        check("R1 osc_fault", int'(osc_fault), 1);
        check("R1 switch_done", int'(switch_done), 1);
        measure_rate(rate);
        check_range("R1 clk_out follows clk_rc", rate, 99, 101);

        // R3: request while the flag is set is ignored
        sel_xt_req = 1'b1; m_req = 1'b1;
        wait_rc(60);
        check("R3 src_xt with fault", int'(src_xt), 0);
        measure_rate(rate);
        check_range("R3 clk_out stays on clk_rc", rate, 99, 101);

        // R6: clear while the external clock is stopped has no effect
        strobe_clear();
        wait_rc(10);
        check("R6 clear while stopped", int'(osc_fault), 1);

        // R6: flag stays set after the external clock starts
        xt_run = 1'b1; m_running = 1'b1;
        wait_rc(60);
        check("R6 sticky after restart", int'(osc_fault), 1);
        check("R3 still internal", int'(src_xt), 0);

        // R6 + R2: clear with live clock, held request then switches
        strobe_clear();
        wait_rc(60);
        check("R6 cleared", int'(osc_fault), 0);
        check("R2 src_xt", int'(src_xt), 1);
        check("R2 switch_done", int'(switch_done), 1);
        measure_rate(rate);
        check_range("R2 clk_out at external rate", rate, 131, 135);

        // R8 + R9: drop request, hand-over is visible, then internal
        saw_busy = 1'b0;
        @(negedge clk_rc) sel_xt_req = 1'b0; m_req = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk_rc);
            if (!switch_done) saw_busy = 1'b1;
        end
        check("R8 switch_done low during hand-over", int'(saw_busy), 1);
        wait_rc(40);
        check("R9 src_xt after drop", int'(src_xt), 0);
        check("R8 switch_done settled", int'(switch_done), 1);
        measure_rate(rate);
        check_range("R9 clk_out back on clk_rc", rate, 99, 101);

        // R4 + R5: lose the external clock while it drives the output
        sel_xt_req = 1'b1; m_req = 1'b1;
        wait_rc(60);
        check("R2 src_xt again", int'(src_xt), 1);
        xt_run = 1'b0; m_running = 1'b0; m_fault = 1'b1;
        lat = 0;
        while (!osc_fault && lat < 40) begin
            @(negedge clk_rc);
            lat++;
        end
        check_range("R4 fault latency", lat, 1, 16);
        wait_rc(40);
        check("R5 src_xt after loss", int'(src_xt), 0);
        check("R5 switch_done after loss", int'(switch_done), 1);
        measure_rate(rate);
        check_range("R5 clk_out on clk_rc after loss", rate, 99, 101);

        // random mix of operations checked against the bench model
        for (int it = 0; it < 40; it++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: begin sel_xt_req = 1'b1; m_req = 1'b1; end
                1: begin sel_xt_req = 1'b0; m_req = 1'b0; end
                2: strobe_clear();
                3: begin xt_run = 1'b0; m_running = 1'b0; m_fault = 1'b1; end
                default: begin xt_run = 1'b1; m_running = 1'b1; end
            endcase
            wait_rc(60);
            check_model($sformatf("R2/R3/R5/R6/R9 random step %0d", it));
        end

        // R7: no narrow pulses on clk_out over the whole run
        check("R7 runt pulses", runts, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule